// File: doc/BRIEF.md
# Flash Status Register Unit

This block is the command and status front end of an asynchronous parallel NOR flash device. A host writes command codes with ordinary bus-write cycles: chip enable and write enable go low, and the code is taken on the data bus when write enable rises. One code selects read-status mode, one clears the error flags, and every other code returns the part to array-read mode and records a command sequence error.

An 8-bit status register tracks a program/erase engine stub. The engine supplies a busy level, suspend set and clear strobes, and an error strobe with a cause code. Error flags are sticky. The ready flag and the two suspend flags follow the engine. The bus-facing copy of the status register is captured on one bus edge and then held. A host that polls must raise output enable, or deselect the device, before its next read can see a newer value.

All bus strobes and the data bus are brought into the system clock domain through a synchroniser before any edge is detected. Array contents are outside this block, so an array-mode read returns zero.

Top module: `flash_stat_unit`

## Requirements
- R1: After reset, the status register holds 80h: ready is set and every other bit is clear. In read-status mode a read returns 0080h.
- R2: While the engine reports busy, status bit 7 is 0. A value captured during busy shows 0 in bits 6..0, so a read returns 0000h.
- R3: Bit 6 (erase suspended) and bit 2 (program suspended) are set by the engine's suspend-set strobe and cleared by its suspend-clear strobe. The select input picks the bit: 1 = erase, 0 = program.
- R4: The engine error strobe ORs its 2-bit result code into bits 5..4 (01 program failure, 10 erase failure, 11 sequence error). The flags stay set after the strobe ends.
- R5: The error strobe also ORs a supply-out-of-range flag into bit 3 and a locked-block flag into bit 1. Both stay set until cleared.
- R6: Command 50h clears bits 5, 4, 3 and 1, leaves bits 7, 6 and 2 unchanged, and returns the part to array-read mode.
- R7: Command 70h enters read-status mode. Any other code, including a code with a nonzero upper byte, returns the part to array-read mode and sets bits 5..4 to 11.
- R8: The bus copy is captured when output enable falls while chip enable is low. It then stays unchanged while output enable stays low, even if the status changes.
- R9: The bus copy is also captured when chip enable falls while output enable is already low.
- R10: The data bus is driven only while both chip enable and output enable are low. In read-status mode it carries the captured status on bits 7..0 and 00h on bits 15..8. In array-read mode it carries 0000h.
- R11: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; the command is taken on its rising edge |
| dq | inout | DQ_W (16) | Bidirectional data bus |
| eng_busy | input | 1 | Engine busy level |
| eng_susp_set | input | 1 | One-cycle strobe that sets a suspend flag |
| eng_susp_clr | input | 1 | One-cycle strobe that clears a suspend flag |
| eng_susp_erase | input | 1 | Suspend flag select: 1 = erase, 0 = program |
| eng_err_set | input | 1 | One-cycle strobe that ORs in the error cause |
| eng_err_code | input | 2 | Result code for bits 5..4 |
| eng_err_vpp | input | 1 | Supply-out-of-range cause |
| eng_err_lock | input | 1 | Locked-block cause |

## Verification
The bench builds the block with its defaults: a 16-bit data bus and a two-stage synchroniser. This lets it check that the upper byte reads zero and that a code with a nonzero upper byte is rejected. Every bus strobe is held for several clocks, longer than the synchroniser and edge-detect latency. Reads can therefore be timed so that an engine update lands while output enable is still low, which shows that the captured value does not change. Chip-enable capture is checked by holding output enable low while chip enable falls.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned ST_W = 8;

  localparam logic [ST_W-1:0] CMD_READ_STATUS = 8'h70;
  localparam logic [ST_W-1:0] CMD_CLEAR_ERR   = 8'h50;

  localparam int unsigned B_READY   = 7;
  localparam int unsigned B_ESUSP   = 6;
  localparam int unsigned B_RES_HI  = 5;
  localparam int unsigned B_RES_LO  = 4;
  localparam int unsigned B_VPP     = 3;
  localparam int unsigned B_PSUSP   = 2;
  localparam int unsigned B_LOCK    = 1;

  localparam logic [ST_W-1:0] ST_RESET    = 8'h80;
  localparam logic [ST_W-1:0] ERR_MASK    = 8'h3A;

  typedef struct packed {
    logic       rs_mode;
    logic       clr;
    logic       bad;
  } cmd_ev_t;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= {WIDTH{RST_BIT}};
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fsr_cmd_dec.sv
module fsr_cmd_dec
  import fsr_pkg::*;
#(
  parameter int unsigned DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_s,
  input  logic            we_s,
  input  logic [DQ_W-1:0] dq_s,
  output cmd_ev_t         ev
);
  logic we_p, we_p_nx;
  logic rs_q, rs_nx;
  logic fire;
  logic is_rs, is_clr;

  assign fire   = we_s && !we_p && !ce_s;
  assign is_rs  = (dq_s[ST_W-1:0] == CMD_READ_STATUS) && (dq_s[DQ_W-1:ST_W] == '0);
  assign is_clr = (dq_s[ST_W-1:0] == CMD_CLEAR_ERR)   && (dq_s[DQ_W-1:ST_W] == '0);

  always_comb begin
    we_p_nx = we_s;
    rs_nx   = rs_q;
    if (fire) rs_nx = is_rs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_p <= 1'b1;
      rs_q <= 1'b0;
    end else begin
      we_p <= we_p_nx;
      rs_q <= rs_nx;
    end
  end

  assign ev.rs_mode = rs_q;
  assign ev.clr     = fire && is_clr;
  assign ev.bad     = fire && !is_rs && !is_clr;

  // R7
  leave_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_rs) |=> !ev.rs_mode);
endmodule

// File: rtl/fsr_status_core.sv
module fsr_status_core
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_s,
  input  logic            oe_s,
  input  cmd_ev_t         ev,
  input  logic            eng_busy,
  input  logic            eng_susp_set,
  input  logic            eng_susp_clr,
  input  logic            eng_susp_erase,
  input  logic            eng_err_set,
  input  logic [1:0]      eng_err_code,
  input  logic            eng_err_vpp,
  input  logic            eng_err_lock,
  output logic [ST_W-1:0] bus_copy
);
  logic [ST_W-1:0] live_q, live_nx;
  logic [ST_W-1:0] copy_q, copy_nx;
  logic            ce_p, oe_p;
  logic            cap;

  assign cap = (!oe_s && oe_p && !ce_s) || (!ce_s && ce_p && !oe_s);

  always_comb begin
    live_nx = live_q;
    live_nx[B_READY] = !eng_busy;
    if (eng_susp_set) begin
      if (eng_susp_erase) live_nx[B_ESUSP] = 1'b1;
      else                live_nx[B_PSUSP] = 1'b1;
    end else if (eng_susp_clr) begin
      if (eng_susp_erase) live_nx[B_ESUSP] = 1'b0;
      else                live_nx[B_PSUSP] = 1'b0;
    end
    if (ev.clr) live_nx = live_nx & ~ERR_MASK;
    if (ev.bad) begin
      live_nx[B_RES_HI] = 1'b1;
      live_nx[B_RES_LO] = 1'b1;
    end
    if (eng_err_set) begin
      live_nx[B_RES_HI] = live_nx[B_RES_HI] | eng_err_code[1];
      live_nx[B_RES_LO] = live_nx[B_RES_LO] | eng_err_code[0];
      live_nx[B_VPP]    = live_nx[B_VPP]    | eng_err_vpp;
      live_nx[B_LOCK]   = live_nx[B_LOCK]   | eng_err_lock;
    end
    live_nx[0] = 1'b0;
  end

  always_comb begin
    copy_nx = copy_q;
    if (cap) copy_nx = live_q[B_READY] ? live_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= ST_RESET;
      copy_q <= ST_RESET;
      ce_p   <= 1'b1;
      oe_p   <= 1'b1;
    end else begin
      live_q <= live_nx;
      copy_q <= copy_nx;
      ce_p   <= ce_s;
      oe_p   <= oe_s;
    end
  end

  assign bus_copy = copy_q;

  // R4
  sticky_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[B_RES_HI] && !ev.clr) |=> live_q[B_RES_HI]);
  // R6
  clear_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.clr && !eng_err_set) |=> ((live_q & ERR_MASK) == '0));
  // R7
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.bad |=> (live_q[B_RES_HI] && live_q[B_RES_LO]));
  // R8
  hold_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(copy_q));
  // R2
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !live_q[B_READY]) |=> (copy_q == '0));
endmodule

// File: rtl/flash_stat_unit.sv
module flash_stat_unit
  import fsr_pkg::*;
#(
  parameter int unsigned DQ_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  inout  wire [DQ_W-1:0]  dq,
  input  logic            eng_busy,
  input  logic            eng_susp_set,
  input  logic            eng_susp_clr,
  input  logic            eng_susp_erase,
  input  logic            eng_err_set,
  input  logic [1:0]      eng_err_code,
  input  logic            eng_err_vpp,
  input  logic            eng_err_lock
);
  localparam int unsigned HI_W = DQ_W - ST_W;

  logic [2:0]      strb_s;
  logic [DQ_W-1:0] dq_s;
  cmd_ev_t         ev;
  logic [ST_W-1:0] bus_copy;
  logic            drive;
  logic [DQ_W-1:0] dq_out;

  fsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(strb_s));

  fsr_sync #(.WIDTH(DQ_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_dq_sync (
    .clk(clk), .rst_n(rst_n), .d(dq), .q(dq_s));

  fsr_cmd_dec #(.DQ_W(DQ_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_s(strb_s[2]), .we_s(strb_s[0]),
    .dq_s(dq_s), .ev(ev));

  fsr_status_core u_core (
    .clk(clk), .rst_n(rst_n), .ce_s(strb_s[2]), .oe_s(strb_s[1]), .ev(ev),
    .eng_busy(eng_busy), .eng_susp_set(eng_susp_set),
    .eng_susp_clr(eng_susp_clr), .eng_susp_erase(eng_susp_erase),
    .eng_err_set(eng_err_set), .eng_err_code(eng_err_code),
    .eng_err_vpp(eng_err_vpp), .eng_err_lock(eng_err_lock),
    .bus_copy(bus_copy));

  assign drive  = !strb_s[2] && !strb_s[1];
  assign dq_out = ev.rs_mode ? {{HI_W{1'b0}}, bus_copy} : '0;
  assign dq     = drive ? dq_out : {DQ_W{1'bz}};

  // R11
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !dq_out[0]);
endmodule

// File: tb/sim_flash_stat_unit.sv
module sim_flash_stat_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic tb_en = 1'b0;
  logic [15:0] tb_val = '0;
  wire  [15:0] dq;
  logic eng_busy = 1'b0, eng_susp_set = 1'b0, eng_susp_clr = 1'b0;
  logic eng_susp_erase = 1'b0, eng_err_set = 1'b0;
  logic [1:0] eng_err_code = 2'b00;
  logic eng_err_vpp = 1'b0, eng_err_lock = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign dq = tb_en ? tb_val : 16'hzzzz;

  always #5 clk = ~clk;

  flash_stat_unit u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq(dq),
    .eng_busy(eng_busy), .eng_susp_set(eng_susp_set),
    .eng_susp_clr(eng_susp_clr), .eng_susp_erase(eng_susp_erase),
    .eng_err_set(eng_err_set), .eng_err_code(eng_err_code),
    .eng_err_vpp(eng_err_vpp), .eng_err_lock(eng_err_lock));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcmd(input logic [15:0] code);
    @(negedge clk);
    tb_val = code; tb_en = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    ce_n = 1'b1; tb_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [15:0] exp);
    @(negedge clk);
    ce_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(req, dq, exp);
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic err(input logic [1:0] code, input logic vpp, input logic lock);
    @(negedge clk);
    eng_err_set = 1'b1; eng_err_code = code; eng_err_vpp = vpp; eng_err_lock = lock;
    @(negedge clk);
    eng_err_set = 1'b0; eng_err_code = 2'b00; eng_err_vpp = 1'b0; eng_err_lock = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic susp(input logic set, input logic erase);
    @(negedge clk);
    eng_susp_erase = erase;
    if (set) eng_susp_set = 1'b1; else eng_susp_clr = 1'b1;
    @(negedge clk);
    eng_susp_set = 1'b0; eng_susp_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    wcmd(16'h0070);
    rd("R1 reset value", 16'h0080);
    rd("R1 R10 repeat read upper byte zero", 16'h0080);
  endtask

  task automatic t_suspend();
    susp(1'b1, 1'b1);
    rd("R3 erase suspend set", 16'h00C0);
    susp(1'b1, 1'b0);
    rd("R3 program suspend set", 16'h00C4);
    susp(1'b0, 1'b1);
    rd("R3 erase suspend cleared", 16'h0084);
    susp(1'b0, 1'b0);
    rd("R3 program suspend cleared", 16'h0080);
  endtask

  task automatic t_errors();
    err(2'b01, 1'b0, 1'b0);
    rd("R4 program error sticky", 16'h0090);
    rd("R4 R11 still set, bit0 zero", 16'h0090);
    err(2'b10, 1'b1, 1'b0);
    rd("R5 erase error and supply flag", 16'h00B8);
    err(2'b00, 1'b0, 1'b1);
    rd("R5 lock flag", 16'h00BA);
  endtask

  task automatic t_busy();
    @(negedge clk); eng_busy = 1'b1;
    repeat (2) @(negedge clk);
    rd("R2 busy masks status", 16'h0000);
    @(negedge clk); eng_busy = 1'b0;
    repeat (2) @(negedge clk);
    rd("R2 ready again, errors retained", 16'h00BA);
  endtask

  task automatic t_clear();
    susp(1'b1, 1'b1);
    wcmd(16'h0050);
    rd("R6 clear returns to array mode", 16'h0000);
    wcmd(16'h0070);
    rd("R6 errors cleared, suspend kept", 16'h00C0);
    susp(1'b0, 1'b1);
  endtask

  task automatic t_badcmd();
    wcmd(16'h00A5);
    rd("R7 unknown code leaves status mode", 16'h0000);
    wcmd(16'h0070);
    rd("R7 sequence error recorded", 16'h00B0);
    wcmd(16'h0050);
    wcmd(16'h0170);
    wcmd(16'h0070);
    rd("R7 nonzero upper byte rejected", 16'h00B0);
    wcmd(16'h0050);
    wcmd(16'h0070);
    rd("R6 clear after sequence error", 16'h0080);
  endtask

  task automatic t_hold();
    @(negedge clk); ce_n = 1'b0;
    repeat (2) @(negedge clk); oe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 first capture", dq, 16'h0080);
    err(2'b01, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 held while oe low", dq, 16'h0080);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);
    oe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 fresh after oe toggle", dq, 16'h0090);
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ce_cap();
    err(2'b00, 1'b1, 1'b0);
    @(negedge clk); oe_n = 1'b0;
    repeat (4) @(negedge clk); ce_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 capture on chip enable", dq, 16'h0098);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R10 array mode after reset", 16'h0000);
    t_reset();
    t_suspend();
    t_errors();
    t_busy();
    t_clear();
    t_badcmd();
    wcmd(16'h0050);
    wcmd(16'h0070);
    t_hold();
    t_ce_cap();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule